// File: doc/BRIEF.md
# Boot Source Selection Sequencer

This block runs once after every reset and settles where the processor starts executing. On the first clock after reset release it captures two boot strap pins and one persistent option bit, then decodes them into a boot space: user flash, system memory (the serial loader), or embedded SRAM. Some strap settings, when the option bit leaves the dual-bank scan enabled, also need a content probe of the two flash banks before the processor may start.

The probe reads the first word of the upper bank over a request/acknowledge read port and tests whether that word could serve as an initial stack pointer, meaning it points into the internal SRAM window. If the upper bank passes, the block names it as the jump target and stops. Only when it fails is the lower bank read and tested the same way. If neither bank passes, the boot space stays at system memory with no jump target, so the serial loader path continues. When the result is final, the block raises a one-cycle done pulse and a valid level that holds until the next reset.

Top module: `boot_select_seq`

## Requirements
- R1: The straps and the option bit are captured only on the first rising clock edge with reset released. Later changes on those inputs have no effect on any output until the next reset.
- R2: With scan_dis_i = 1 and strap_a_i = 0 (strap_b_i don't care), space_o = 2'b00 (user flash), jump_o = 2'b00 (none), and no read is issued.
- R3: With strap_a_i = 1, strap_b_i = 0 and scan_dis_i = 1, space_o = 2'b01 (system memory), jump_o = 2'b00, and no read is issued.
- R4: With strap_a_i = 1 and strap_b_i = 1, space_o = 2'b10 (SRAM) and no read is issued, whatever the option bit holds.
- R5: With scan_dis_i = 0 and either strap_a_i = 0, or strap_a_i = 1 with strap_b_i = 0, space_o = 2'b01 and the bank probe runs.
- R6: The first probe read uses address 0x0808_0000 (upper bank). If that word is valid, jump_o = 2'b10 and no second read follows.
- R7: A second read, at 0x0800_0000 (lower bank), occurs only after the upper word was invalid. If that word is valid, jump_o = 2'b01.
- R8: When both words are invalid, jump_o = 2'b00 and space_o stays 2'b01.
- R9: A word is valid when SRAM_BASE <= word <= SRAM_BASE + SRAM_SIZE, with the top included. Zero, SRAM_BASE - 1 and SRAM_BASE + SRAM_SIZE + 1 are invalid.
- R10: rd_req_o stays high with a stable rd_addr_o until rd_ack_i is seen, however long that takes. A cycle with both high completes one read, and at most two reads complete per reset.
- R11: done_o is high for exactly one cycle per reset. valid_o rises together with done_o and stays high, and space_o and jump_o stay constant after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_a_i | input | 1 | Primary boot strap |
| strap_b_i | input | 1 | Secondary boot strap, used when strap_a_i is 1 |
| scan_dis_i | input | 1 | Option bit; 1 disables the dual-bank probe |
| rd_req_o | output | 1 | Read request to the flash |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid with it |
| rd_data_i | input | DATA_W | Read data |
| space_o | output | 2 | Boot space: 00 flash, 01 system, 10 SRAM |
| jump_o | output | 2 | Jump target: 00 none, 01 lower bank, 10 upper bank |
| done_o | output | 1 | One-cycle pulse when the result is final |
| valid_o | output | 1 | High from done until next reset |

## Verification
The bench sweeps all eight strap and option combinations. For each setting that probes, it crosses seven stack-pointer words on each bank: zero, one below the SRAM base, the base, the middle, the inclusive top, one past the top, and all ones. Acknowledge latency also varies. A design that tested the lower bank first, or read it after a valid upper word, shows the wrong address order or a read count of two. An exclusive top or an off-by-one lower bound flips the verdict at the edge words. After the first edge the bench toggles the straps and the option bit. A design that sampled them continuously then reports a different space. A probe that ignored the option bit, or ran in SRAM mode, shows reads where none belong.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

   typedef enum logic [1:0] {
      BS_FLASH  = 2'b00,
      BS_SYSTEM = 2'b01,
      BS_SRAM   = 2'b10
   } boot_space_e;

   typedef enum logic [1:0] {
      JT_NONE  = 2'b00,
      JT_BANK1 = 2'b01,
      JT_BANK2 = 2'b10
   } jump_tgt_e;

   typedef enum logic [1:0] {
      ST_SAMPLE   = 2'd0,
      ST_PROBE_HI = 2'd1,
      ST_PROBE_LO = 2'd2,
      ST_HOLD     = 2'd3
   } probe_state_e;

endpackage

// File: rtl/strap_decode.sv
module strap_decode
   import boot_sel_pkg::*;
(
   input  logic        strap_a,
   input  logic        strap_b,
   input  logic        scan_dis,
   output boot_space_e space,
   output logic        probe_en
);

   always_comb begin
      space    = BS_SYSTEM;
      probe_en = 1'b0;
      if (strap_a && strap_b) begin
         // SRAM boot never probes the banks
         space    = BS_SRAM;
         probe_en = 1'b0;
      end else if (!strap_a && scan_dis) begin
         space    = BS_FLASH;
         probe_en = 1'b0;
      end else begin
         // system memory, with the probe unless the option disables it
         space    = BS_SYSTEM;
         probe_en = !scan_dis;
      end
   end

endmodule

// File: rtl/stack_window_check.sv
module stack_window_check #(
   parameter int unsigned       DATA_W   = 32,
   parameter logic [DATA_W-1:0] WIN_BASE = 32'h2000_0000,
   parameter logic [DATA_W-1:0] WIN_SIZE = 32'h0001_0000,
   parameter bit                INCL_TOP = 1'b1
) (
   input  logic [DATA_W-1:0] word,
   output logic              in_window
);

   localparam logic [DATA_W:0] BASE_EXT = {1'b0, WIN_BASE};
   localparam logic [DATA_W:0] TOP_EXT  = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

   if (WIN_SIZE == '0) begin : g_bad_size
      $error("stack_window_check: WIN_SIZE must be nonzero");
   end
   if (TOP_EXT[DATA_W]) begin : g_bad_wrap
      $error("stack_window_check: window wraps past the address space");
   end

   logic [DATA_W:0] word_ext;
   logic            lo_ok;
   logic            hi_ok;

   assign word_ext = {1'b0, word};
   assign lo_ok    = word_ext >= BASE_EXT;

   if (INCL_TOP) begin : g_incl_top
      assign hi_ok = word_ext <= TOP_EXT;
   end else begin : g_excl_top
      assign hi_ok = word_ext < TOP_EXT;
   end

   assign in_window = lo_ok && hi_ok;

endmodule

// File: rtl/bank_probe_fsm.sv
module bank_probe_fsm
   import boot_sel_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter logic [ADDR_W-1:0] BANK1_BASE = 32'h0800_0000,
   parameter logic [ADDR_W-1:0] BANK2_BASE = 32'h0808_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  boot_space_e       space_d,
   input  logic              probe_en,
   input  logic              rd_ack,
   input  logic              word_ok,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output boot_space_e       space_q,
   output jump_tgt_e         jump_q,
   output logic              done,
   output logic              valid
);

   probe_state_e state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_SAMPLE;
         rd_req  <= 1'b0;
         rd_addr <= '0;
         space_q <= BS_FLASH;
         jump_q  <= JT_NONE;
         done    <= 1'b0;
         valid   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_SAMPLE: begin
               space_q <= space_d;
               if (probe_en) begin
                  rd_req  <= 1'b1;
                  rd_addr <= BANK2_BASE;
                  state_q <= ST_PROBE_HI;
               end else begin
                  done    <= 1'b1;
                  valid   <= 1'b1;
                  state_q <= ST_HOLD;
               end
            end
            ST_PROBE_HI: begin
               if (rd_ack) begin
                  if (word_ok) begin
                     rd_req  <= 1'b0;
                     jump_q  <= JT_BANK2;
                     done    <= 1'b1;
                     valid   <= 1'b1;
                     state_q <= ST_HOLD;
                  end else begin
                     rd_addr <= BANK1_BASE;
                     state_q <= ST_PROBE_LO;
                  end
               end
            end
            ST_PROBE_LO: begin
               if (rd_ack) begin
                  rd_req  <= 1'b0;
                  jump_q  <= word_ok ? JT_BANK1 : JT_NONE;
                  done    <= 1'b1;
                  valid   <= 1'b1;
                  state_q <= ST_HOLD;
               end
            end
            default: begin
               state_q <= ST_HOLD;
            end
         endcase
      end
   end

   // checker-side count of completed reads
   logic [1:0] reads_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           reads_q <= 2'd0;
      else if (rd_req && rd_ack && reads_q != 2'd3) reads_q <= reads_q + 2'd1;
   end

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
   // R10
   read_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reads_q <= 2'd2);
   // R6
   first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && reads_q == 2'd0 |-> rd_addr == BANK2_BASE);
   // R7
   second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && reads_q == 2'd1 |-> rd_addr == BANK1_BASE);
   // R4
   sram_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && space_q == BS_SRAM |-> reads_q == 2'd0);
   // R8
   two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid && reads_q == 2'd2 |-> jump_q != JT_BANK2);
   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R11
   valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> valid && $stable(space_q) && $stable(jump_q));

endmodule

// File: rtl/boot_select_seq.sv
module boot_select_seq
   import boot_sel_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 32,
   parameter int unsigned       DATA_W     = 32,
   parameter logic [DATA_W-1:0] SRAM_BASE  = 32'h2000_0000,
   parameter logic [DATA_W-1:0] SRAM_SIZE  = 32'h0001_0000,
   parameter logic [ADDR_W-1:0] BANK1_BASE = 32'h0800_0000,
   parameter logic [ADDR_W-1:0] BANK2_BASE = 32'h0808_0000,
   parameter bit                INCL_TOP   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              strap_a_i,
   input  logic              strap_b_i,
   input  logic              scan_dis_i,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic              rd_ack_i,
   input  logic [DATA_W-1:0] rd_data_i,
   output logic [1:0]        space_o,
   output logic [1:0]        jump_o,
   output logic              done_o,
   output logic              valid_o
);

   if (BANK1_BASE == BANK2_BASE) begin : g_bad_banks
      $error("boot_select_seq: bank bases must differ");
   end
   if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
      $error("boot_select_seq: widths too small");
   end

   boot_space_e dec_space;
   boot_space_e fin_space;
   jump_tgt_e   fin_jump;
   logic        probe_en;
   logic        word_ok;

   strap_decode u_decode (
      .strap_a  (strap_a_i),
      .strap_b  (strap_b_i),
      .scan_dis (scan_dis_i),
      .space    (dec_space),
      .probe_en (probe_en)
   );

   stack_window_check #(
      .DATA_W   (DATA_W),
      .WIN_BASE (SRAM_BASE),
      .WIN_SIZE (SRAM_SIZE),
      .INCL_TOP (INCL_TOP)
   ) u_window (
      .word      (rd_data_i),
      .in_window (word_ok)
   );

   bank_probe_fsm #(
      .ADDR_W     (ADDR_W),
      .BANK1_BASE (BANK1_BASE),
      .BANK2_BASE (BANK2_BASE)
   ) u_fsm (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .space_d  (dec_space),
      .probe_en (probe_en),
      .rd_ack   (rd_ack_i),
      .word_ok  (word_ok),
      .rd_req   (rd_req_o),
      .rd_addr  (rd_addr_o),
      .space_q  (fin_space),
      .jump_q   (fin_jump),
      .done     (done_o),
      .valid    (valid_o)
   );

   assign space_o = fin_space;
   assign jump_o  = fin_jump;

   // R11
   done_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> valid_o);
   // R2
   flash_nojump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o && space_o == 2'b00 |-> jump_o == 2'b00);

endmodule

// File: tb/boot_select_seq_bench.sv
module boot_select_seq_bench;

   localparam logic [31:0] BASE  = 32'h2000_0000;
   localparam logic [31:0] SIZE  = 32'h0000_5000;
   localparam logic [31:0] BK1   = 32'h0800_0000;
   localparam logic [31:0] BK2   = 32'h0808_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sa = 1'b0, sb = 1'b0, sdis = 1'b1;
   logic        req;
   logic [31:0] addr;
   logic        ack = 1'b0;
   logic [31:0] rdata = '0;
   logic [1:0]  space, jump;
   logic        done, valid;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   boot_select_seq #(
      .SRAM_BASE (BASE),
      .SRAM_SIZE (SIZE)
   ) u_boot_select_seq (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .strap_a_i  (sa),
      .strap_b_i  (sb),
      .scan_dis_i (sdis),
      .rd_req_o   (req),
      .rd_addr_o  (addr),
      .rd_ack_i   (ack),
      .rd_data_i  (rdata),
      .space_o    (space),
      .jump_o     (jump),
      .done_o     (done),
      .valid_o    (valid)
   );

   // flash responder, driven on falling edges
   logic [31:0] mem_hi, mem_lo;
   int          lat = 0;
   int          wait_cnt = 0;
   int          nreads = 0;
   logic [31:0] addr_log [0:3];

   always @(negedge clk) begin
      if (!rst_n) begin
         ack = 1'b0;
         wait_cnt = 0;
      end else if (ack) begin
         ack = 1'b0;
         wait_cnt = 0;
      end else if (req) begin
         if (wait_cnt >= lat) begin
            ack   = 1'b1;
            rdata = (addr == BK2) ? mem_hi : (addr == BK1) ? mem_lo : 32'hDEAD_BEEF;
            if (nreads < 4) addr_log[nreads] = addr;
            nreads = nreads + 1;
         end else begin
            wait_cnt = wait_cnt + 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic bit in_win(input logic [31:0] w);
      logic [32:0] top;
      top = {1'b0, BASE} + {1'b0, SIZE};
      return ({1'b0, w} >= {1'b0, BASE}) && ({1'b0, w} <= top);
   endfunction

   task automatic run_case(input logic dis, input logic a, input logic b,
                           input logic [31:0] w2, input logic [31:0] w1, input int l);
      logic [1:0] e_space, e_jump;
      bit         probe;
      int         e_reads;
      int         cyc;
      @(negedge clk);
      rst_n = 1'b0;
      sdis = dis; sa = a; sb = b;
      mem_hi = w2; mem_lo = w1; lat = l;
      @(negedge clk);
      nreads = 0;
      @(negedge clk);
      // R11 reset state
      chk("R11 reset outputs", {27'd0, req, space, jump, done, valid}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      // R1 flip straps after the sampling edge
      sa = ~a; sb = ~b; sdis = ~dis;

      if (a && b)          begin e_space = 2'b10; probe = 1'b0; end
      else if (!a && dis)  begin e_space = 2'b00; probe = 1'b0; end
      else                 begin e_space = 2'b01; probe = !dis; end
      e_jump = 2'b00; e_reads = 0;
      if (probe) begin
         if (in_win(w2))      begin e_jump = 2'b10; e_reads = 1; end
         else if (in_win(w1)) begin e_jump = 2'b01; e_reads = 2; end
         else                 begin e_jump = 2'b00; e_reads = 2; end
      end

      cyc = 0;
      while (!done && cyc < 100) begin
         @(negedge clk);
         cyc++;
      end
      chk("R11 done seen", {31'd0, done}, 32'd1);
      chk("R11 valid with done", {31'd0, valid}, 32'd1);
      if (a && b)       chk("R4 space sram", {30'd0, space}, {30'd0, e_space});
      else if (probe)   chk("R5 space system", {30'd0, space}, {30'd0, e_space});
      else if (!a)      chk("R2 space flash", {30'd0, space}, {30'd0, e_space});
      else              chk("R3 space system", {30'd0, space}, {30'd0, e_space});
      chk("R1 result after strap flip", {30'd0, space}, {30'd0, e_space});
      if (probe) begin
         if (e_reads == 1)      chk("R6 jump", {30'd0, jump}, {30'd0, e_jump});
         else if (e_jump != 0)  chk("R7 jump", {30'd0, jump}, {30'd0, e_jump});
         else                   chk("R8 jump", {30'd0, jump}, {30'd0, e_jump});
         chk("R9 verdict reads", nreads, e_reads);
         chk("R6 first addr", addr_log[0], BK2);
         if (e_reads == 2) chk("R7 second addr", addr_log[1], BK1);
      end else begin
         chk("R2 no jump", {30'd0, jump}, 32'd0);
         chk("R4 no reads", nreads, 0);
      end
      @(negedge clk);
      chk("R11 done one cycle", {31'd0, done}, 32'd0);
      repeat (4) @(negedge clk);
      chk("R11 valid held", {31'd0, valid}, 32'd1);
      chk("R11 jump stable", {30'd0, jump}, {30'd0, e_jump});
      chk("R10 read count final", nreads, e_reads);
      chk("R10 request dropped", {31'd0, req}, 32'd0);
   endtask

   initial begin : wdog
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [31:0] pts [0:6];
      pts[0] = 32'h0000_0000;
      pts[1] = BASE - 32'd1;
      pts[2] = BASE;
      pts[3] = BASE + (SIZE >> 1);
      pts[4] = BASE + SIZE;
      pts[5] = BASE + SIZE + 32'd1;
      pts[6] = 32'hFFFF_FFFF;
      for (int c = 0; c < 8; c++) begin
         logic d, a, b;
         d = c[2]; a = c[1]; b = c[0];
         if (!d && !(a && b)) begin
            for (int i = 0; i < 7; i++)
               for (int j = 0; j < 7; j++)
                  run_case(d, a, b, pts[i], pts[j], (i + j) % 4);
         end else begin
            run_case(d, a, b, pts[2], pts[2], 1);
         end
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule